// File: doc/BRIEF.md
# Shared Exclusive Access Monitor

This block tracks a single reservation for atomic read-modify-write sequences issued by several processor cores. A core opens a reservation with a load-exclusive. The monitor then records the upper part of the physical address and the number of the requesting core. A later store-exclusive asks the monitor whether its write may commit. The monitor answers with a pass or fail flag one clock later.

The address is compared at a configurable granule. Every address that differs only below bit `GRANULE_LSB` maps to the same reservation. There is exactly one entry for the whole system, so a load-exclusive from any core displaces the current holder.

Ordinary loads and stores are invisible to the monitor, even when they hit the reserved granule. The decision uses only the stored tag, the stored owner and the valid bit. It takes no input from cache state.

Top module: `excl_mon_top`

## Requirements
- R1: After reset the reservation is invalid, `rsp_vld` and `rsp_pass` are 0, and a store-exclusive issued before any load-exclusive fails.
- R2: A valid request with `req_kind` = 1 (load-exclusive) records `req_addr[31:GRANULE_LSB]` and `req_core` and marks the reservation valid, replacing any earlier reservation.
- R3: A valid request with `req_kind` = 2 (store-exclusive) passes only if the reservation is valid, its tag equals `req_addr[31:GRANULE_LSB]` and its owner equals `req_core`. Addresses that differ only in bits below `GRANULE_LSB` count as equal. Any other store-exclusive fails.
- R4: Every store-exclusive, passing or failing, invalidates the reservation, so a second store-exclusive without a new load-exclusive fails.
- R5: Cycles with `req_vld` = 0, and valid requests with `req_kind` = 0 or 3 (ordinary access), leave the reservation unchanged. The sequence load-exclusive, ordinary load, ordinary store, store-exclusive to one address from one core therefore passes.
- R6: A load-exclusive from a second core takes the reservation. A following store-exclusive from the first core fails, and one from the second core to the same granule passes.
- R7: `rsp_vld` is 1 exactly in the cycle after a store-exclusive request and 0 otherwise. `rsp_pass` carries the result in that cycle and is 0 whenever `rsp_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0/3 ordinary, 1 load-exclusive, 2 store-exclusive |
| req_addr | input | 32 | Physical address of the access |
| req_core | input | CORE_W | Number of the requesting core |
| rsp_vld | output | 1 | Store-exclusive result strobe |
| rsp_pass | output | 1 | 1 when the store-exclusive may commit |

## Verification
The assertions assume that `req_kind` and `req_core` are known whenever `req_vld` is high, and that `req_core` stays below `NUM_CORES`. They also assume that reset is held for at least one clock edge before the first request. The stimulus draws the core number from the range 0 to `NUM_CORES`-1 only. It drives every input at the falling edge and keeps `rst_n` low for several cycles at the start. The random addresses are confined to a few neighbouring granules with random low bits, so that tag hits, tag misses and hits within one granule all occur often.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    ACC_PLAIN     = 2'd0,
    ACC_LDEX      = 2'd1,
    ACC_STEX      = 2'd2,
    ACC_PLAIN_ALT = 2'd3
  } acc_kind_e;

  function automatic int core_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/excl_mon_classify.sv
module excl_mon_classify
  import excl_mon_pkg::*;
(
  input  logic       req_vld_i,
  input  logic [1:0] req_kind_i,
  output logic       is_ldex_o,
  output logic       is_stex_o
);

  acc_kind_e kind;

  always_comb begin
    kind      = acc_kind_e'(req_kind_i);
    is_ldex_o = 1'b0;
    is_stex_o = 1'b0;
    if (req_vld_i) begin
      unique case (kind)
        ACC_LDEX: is_ldex_o = 1'b1;
        ACC_STEX: is_stex_o = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/excl_mon_resv.sv
module excl_mon_resv
  import excl_mon_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int GRANULE_LSB = 4,
  parameter int CORE_W      = 2,
  localparam int TAG_W      = ADDR_W - GRANULE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CORE_W-1:0] core_i,
  output logic              rsv_valid_o,
  output logic [CORE_W-1:0] rsv_core_o,
  output logic              match_o
);

  logic [TAG_W-1:0]       rsv_tag;
  logic [TAG_W-1:0]       req_tag;
  logic                   tag_eq;
  logic                   owner_eq;
  logic [GRANULE_LSB-1:0] unused_low;

  function automatic logic [TAG_W-1:0] granule_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:GRANULE_LSB];
  endfunction

  assign req_tag    = granule_tag(addr_i);
  assign unused_low = addr_i[GRANULE_LSB-1:0];
  assign tag_eq     = (rsv_tag == req_tag);

  generate
    if (NUM_CORES == 1) begin : g_single_core
      logic unused_core;
      assign unused_core = ^{core_i, rsv_core_o};
      assign owner_eq    = 1'b1;
    end else begin : g_multi_core
      assign owner_eq = (rsv_core_o == core_i);
    end
  endgenerate

  assign match_o = rsv_valid_o && tag_eq && owner_eq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_valid_o <= 1'b0;
      rsv_tag     <= '0;
      rsv_core_o  <= '0;
    end else if (set_i) begin
      rsv_valid_o <= 1'b1;
      rsv_tag     <= req_tag;
      rsv_core_o  <= core_i;
    end else if (clr_i) begin
      rsv_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/excl_mon_resp.sv
module excl_mon_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic stex_i,
  input  logic match_i,
  output logic rsp_vld_o,
  output logic rsp_pass_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld_o  <= 1'b0;
      rsp_pass_o <= 1'b0;
    end else begin
      rsp_vld_o  <= stex_i;
      rsp_pass_o <= stex_i && match_i;
    end
  end

endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int GRANULE_LSB = 4,
  localparam int CORE_W     = core_width(NUM_CORES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [1:0]        req_kind,
  input  logic [31:0]       req_addr,
  input  logic [CORE_W-1:0] req_core,
  output logic              rsp_vld,
  output logic              rsp_pass
);

  logic              is_ldex;
  logic              is_stex;
  logic              rsv_valid;
  logic [CORE_W-1:0] rsv_core;
  logic              rsv_match;

  excl_mon_classify u_classify (
    .req_vld_i  (req_vld),
    .req_kind_i (req_kind),
    .is_ldex_o  (is_ldex),
    .is_stex_o  (is_stex)
  );

  excl_mon_resv #(
    .NUM_CORES   (NUM_CORES),
    .GRANULE_LSB (GRANULE_LSB),
    .CORE_W      (CORE_W)
  ) u_resv (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (is_ldex),
    .clr_i       (is_stex),
    .addr_i      (req_addr),
    .core_i      (req_core),
    .rsv_valid_o (rsv_valid),
    .rsv_core_o  (rsv_core),
    .match_o     (rsv_match)
  );

  excl_mon_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stex_i     (is_stex),
    .match_i    (rsv_match),
    .rsp_vld_o  (rsp_vld),
    .rsp_pass_o (rsp_pass)
  );

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int CORE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [1:0]        req_kind,
  input logic [CORE_W-1:0] req_core,
  input logic              rsp_vld,
  input logic              rsp_pass,
  input logic              rsv_valid,
  input logic [CORE_W-1:0] rsv_core,
  input logic              is_ldex,
  input logic              is_stex
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsv_valid && !rsp_vld); // R1

  AST_LDEX_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd1) |=> rsv_valid && rsv_core == $past(req_core)); // R2

  AST_PASS_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd2 && !rsv_valid) |=> !rsp_pass); // R3

  AST_STEX_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd2) |=> !rsv_valid); // R4

  AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_vld || req_kind == 2'd0 || req_kind == 2'd3) |=> $stable(rsv_valid) && $stable(rsv_core)); // R5

  AST_FOREIGN_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd2 && rsv_core != req_core) |=> !rsp_pass); // R6

  AST_RSP_AFTER_STEX: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd2) |=> rsp_vld); // R7

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && req_kind == 2'd2) |=> !rsp_vld); // R7

  AST_PASS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pass |-> rsp_vld); // R7

  AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_ldex && is_stex)); // R2

endmodule

bind excl_mon_top excl_mon_chk #(.CORE_W(CORE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_kind  (req_kind),
  .req_core  (req_core),
  .rsp_vld   (rsp_vld),
  .rsp_pass  (rsp_pass),
  .rsv_valid (rsv_valid),
  .rsv_core  (rsv_core),
  .is_ldex   (is_ldex),
  .is_stex   (is_stex)
);

// File: tb/test_excl_mon_top.sv
`timescale 1ns/1ps
module test_excl_mon_top;

  localparam int NC = 4;
  localparam int GL = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_vld = 1'b0;
  logic [1:0]    req_kind = 2'd0;
  logic [31:0]   req_addr = '0;
  logic [CW-1:0] req_core = '0;
  logic          rsp_vld;
  logic          rsp_pass;

  int n_chk = 0;
  int n_bad = 0;

  bit          m_valid = 1'b0;
  logic [31:0] m_tag = '0;
  logic [CW-1:0] m_core = '0;

  always #2 clk = ~clk;

  excl_mon_top #(.NUM_CORES(NC), .GRANULE_LSB(GL)) i_excl_mon_top (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
    .req_addr(req_addr), .req_core(req_core), .rsp_vld(rsp_vld), .rsp_pass(rsp_pass)
  );

  function automatic logic [31:0] bench_gran(input logic [31:0] a);
    return a >> GL;
  endfunction

  function automatic bit bench_pass(input logic [31:0] a, input logic [CW-1:0] c);
    return m_valid && (bench_gran(a) == m_tag) && (c == m_core);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req, input bit vld, input logic [1:0] kind,
                      input logic [31:0] addr, input logic [CW-1:0] core);
    bit e_vld;
    bit e_pass;
    e_vld  = vld && kind == 2'd2;
    e_pass = e_vld && bench_pass(addr, core);
    if (vld && kind == 2'd1) begin
      m_valid = 1'b1; m_tag = bench_gran(addr); m_core = core;
    end else if (e_vld) begin
      m_valid = 1'b0;
    end
    req_vld = vld; req_kind = kind; req_addr = addr; req_core = core;
    @(negedge clk);
    check({req, " rsp_vld"}, rsp_vld, e_vld);
    check({req, " rsp_pass"}, rsp_pass, e_pass);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check("R1 reset rsp_vld", rsp_vld, 1'b0);
    check("R1 reset rsp_pass", rsp_pass, 1'b0);
    rst_n = 1'b1;
    step("R1 stex after reset", 1, 2'd2, 32'h1000_0040, 2'd0);

    step("R2 ldex core1", 1, 2'd1, 32'h1000_0040, 2'd1);
    step("R3 stex same granule", 1, 2'd2, 32'h1000_004C, 2'd1);
    step("R4 second stex", 1, 2'd2, 32'h1000_0040, 2'd1);

    step("R5 ldex", 1, 2'd1, 32'h2000_0100, 2'd2);
    step("R5 plain load", 1, 2'd0, 32'h2000_0100, 2'd2);
    step("R5 plain store", 1, 2'd3, 32'h2000_0100, 2'd2);
    step("R5 plain other core", 1, 2'd0, 32'h2000_0100, 2'd0);
    step("R5 idle", 0, 2'd2, 32'h2000_0100, 2'd2);
    step("R5 stex passes", 1, 2'd2, 32'h2000_0100, 2'd2);

    step("R6 ldex core0", 1, 2'd1, 32'h3000_0000, 2'd0);
    step("R6 ldex core3", 1, 2'd1, 32'h3000_0000, 2'd3);
    step("R6 stex old owner", 1, 2'd2, 32'h3000_0000, 2'd0);
    step("R6 ldex core3 again", 1, 2'd1, 32'h3000_0000, 2'd3);
    step("R6 stex new owner", 1, 2'd2, 32'h3000_0008, 2'd3);

    step("R3 ldex", 1, 2'd1, 32'h4000_0000, 2'd1);
    step("R3 stex next granule", 1, 2'd2, 32'h4000_0010, 2'd1);
    step("R3 ldex", 1, 2'd1, 32'h4000_0000, 2'd1);
    step("R3 stex wrong core", 1, 2'd2, 32'h4000_0000, 2'd2);
    step("R3 ldex high", 1, 2'd1, 32'hF000_0000, 2'd1);
    step("R3 stex top bit differs", 1, 2'd2, 32'h7000_0000, 2'd1);
    step("R7 idle after stex", 0, 2'd0, 32'h0, 2'd0);

    for (int i = 0; i < 4000; i++) begin
      bit          v;
      logic [1:0]  k;
      logic [31:0] a;
      logic [CW-1:0] c;
      v = ($urandom_range(0, 7) != 0);
      k = 2'($urandom_range(0, 3));
      a = 32'h5000_0000 | (32'($urandom_range(0, 2)) << GL) | 32'($urandom_range(0, 15));
      c = CW'($urandom_range(0, NC - 1));
      step("R7 random", v, k, a, c);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule